// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter and Reporter

This block sits between the PWM generator and the gate outputs of a three-phase half-bridge with six switches. Each switch has an asynchronous comparator flag that goes high when the voltage across the conducting switch exceeds a trip level. A flag counts only while its switch is commanded on. In current-limit mode, a switch that trips is held off for the rest of its PWM cycle. The other five switches keep running. A single active-low warning output reports the event for a bounded time.

The warning time is set by a cycle counter of `TICKS_PER_US * WINDOW_US` clock cycles. A trip from another switch during an active report restarts this counter. When several switches have tripped, the early release happens only after every one of them has begun a new PWM cycle. A mode input can select latched shutdown instead: the first qualified trip turns all gates off until reset. A separate fault-shutdown input forces every gate output low at once. The PWM inputs must be synchronous to `clk`. The comparator flags pass through a two-flop synchronizer.

Top module: `ocp_limiter`

## Requirements
- R1: A synchronized flag is acted on only while its `pwm_in` bit is high and `fault_off` is low. A flag at any other time changes neither `gate_out` nor `warn_n`.
- R2: With `mode_latch` low, a flag held high across three rising clock edges turns that switch's `gate_out` bit low after the third edge. The bit stays low until its `pwm_in` shows a rising edge. The other gate bits keep following their PWM inputs.
- R3: With `mode_latch` low, `warn_n` goes low at the same edge that blanks the switch. It stays low for at most `TIMEOUT_CYC` clock cycles after the most recent trip.
- R4: For a single tripped switch, a rising edge on its `pwm_in` releases `warn_n` (back to 1) at that clock edge, before the timeout.
- R5: A trip on another switch while `warn_n` is low restarts the timeout count from zero.
- R6: While several switches are pending in one report, an early release happens only after every pending switch has had a `pwm_in` rising edge. Otherwise the release waits for the timeout.
- R7: While `fault_off` is 1, all `gate_out` bits are 0 in the same cycle.
- R8: With `mode_latch` high (1 = latched shutdown, 0 = current limit), a qualified trip drives all `gate_out` bits to 0 and `warn_n` to 0. Both stay there until `rst`, whatever `mode_latch` and `pwm_in` do afterwards.
- R9: During and after reset, no switch is blanked, `gate_out` equals `pwm_in`, and `warn_n` is 1.
- R10: A new PWM cycle means a `pwm_in` bit that is 1 in the current cycle and was 0 in the previous one. At that edge the gate bit turns on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | NSW | Per-switch on command from the PWM generator |
| oc_flag_in | input | NSW | Asynchronous per-switch overcurrent comparator flags |
| mode_latch | input | 1 | 0 = cycle-by-cycle limiting, 1 = latched shutdown |
| fault_off | input | 1 | Forces all gate outputs low |
| gate_out | output | NSW | Gate commands to the drivers |
| warn_n | output | 1 | Active-low overcurrent warning |

## Verification
The hardest situation to reach is a report that stays open because of staggered trips. In that case the timer restarts, and the release has to wait until several switches have each started a new PWM cycle. Random stimulus almost never lines this up. Directed sequences therefore trip one switch, then trip a second one well inside the window, and then cycle the PWM inputs one at a time, checking `warn_n` between those steps. A constrained-random phase with sparse flags and occasional fault pulses follows. It is compared every cycle against a bench model built from the requirements.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    localparam int unsigned NSW_DEFAULT = 6;

    typedef enum logic {
        MODE_LIMIT = 1'b0,
        MODE_LATCH = 1'b1
    } oc_mode_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/ocp_phase_gate.sv
module ocp_phase_gate (
    input  logic clk,
    input  logic rst,
    input  logic pwm,
    input  logic en,
    input  logic oc_s,
    output logic trip,
    output logic rise,
    output logic gate
);
    typedef struct packed {
        logic pwm_prev;
        logic blank;
    } ph_st_t;

    ph_st_t s_d, s_q;
    logic   on_cmd;
    logic   blank_eff;

    always_comb begin
        rise      = pwm & ~s_q.pwm_prev;
        on_cmd    = pwm & en;
        blank_eff = s_q.blank & ~rise;
        trip      = oc_s & on_cmd & ~blank_eff;
        gate      = on_cmd & ~blank_eff;
        s_d          = s_q;
        s_d.pwm_prev = pwm;
        s_d.blank    = blank_eff | trip;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (s_q.blank && !(pwm && !s_q.pwm_prev)) |=> s_q.blank); // R2

    AST_TRIP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.blank) |-> $past(pwm && en)); // R1
endmodule

// File: rtl/ocp_report.sv
module ocp_report
    import ocp_pkg::*;
#(
    parameter int unsigned NSW          = NSW_DEFAULT,
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned WINDOW_US    = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSW-1:0] trip,
    input  logic [NSW-1:0] rise,
    input  logic           mode_latch,
    output logic           shut,
    output logic           warn_n
);
    localparam int unsigned TIMEOUT_CYC = TICKS_PER_US * WINDOW_US;
    localparam int unsigned CW          = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic           active;
        logic           shut;
        logic [NSW-1:0] pend;
        logic [CW-1:0]  cnt;
    } rep_st_t;

    rep_st_t  s_d, s_q;
    oc_mode_e mode;
    logic     any_trip;

    always_comb begin
        mode     = oc_mode_e'(mode_latch);
        any_trip = |trip;
        s_d      = s_q;
        if (s_q.active) begin
            s_d.pend = s_q.pend & ~rise;
            s_d.cnt  = s_q.cnt + CW'(1);
        end
        if (any_trip && mode == MODE_LIMIT) begin
            s_d.active = 1'b1;
            s_d.pend   = s_d.pend | trip;
            s_d.cnt    = '0;
        end else if (s_q.active &&
                     (s_q.cnt == CW'(TIMEOUT_CYC - 1) || s_d.pend == '0)) begin
            s_d.active = 1'b0;
            s_d.pend   = '0;
            s_d.cnt    = '0;
        end
        if (any_trip && mode == MODE_LATCH) s_d.shut = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign shut   = s_q.shut;
    assign warn_n = ~(s_q.active | s_q.shut);

    AST_WARN_BOUND: assert property (@(posedge clk) disable iff (rst)
        s_q.active |-> (s_q.cnt < CW'(TIMEOUT_CYC))); // R3

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
        (s_q.active && any_trip && !mode_latch) |=> (s_q.active && s_q.cnt == '0)); // R5

    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        s_q.shut |=> (s_q.shut && !warn_n)); // R8
endmodule

// File: rtl/ocp_limiter.sv
module ocp_limiter
    import ocp_pkg::*;
#(
    parameter int unsigned NSW          = NSW_DEFAULT,
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned WINDOW_US    = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSW-1:0] pwm_in,
    input  logic [NSW-1:0] oc_flag_in,
    input  logic           mode_latch,
    input  logic           fault_off,
    output logic [NSW-1:0] gate_out,
    output logic           warn_n
);
    logic [NSW-1:0] oc_s;
    logic [NSW-1:0] trip;
    logic [NSW-1:0] rise;
    logic           shut;
    logic           en;

    assign en = ~fault_off & ~shut;

    ocp_sync #(.W(NSW)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (oc_flag_in),
        .sync_out (oc_s)
    );

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        ocp_phase_gate u_gate (
            .clk  (clk),
            .rst  (rst),
            .pwm  (pwm_in[i]),
            .en   (en),
            .oc_s (oc_s[i]),
            .trip (trip[i]),
            .rise (rise[i]),
            .gate (gate_out[i])
        );
    end

    ocp_report #(
        .NSW          (NSW),
        .TICKS_PER_US (TICKS_PER_US),
        .WINDOW_US    (WINDOW_US)
    ) u_report (
        .clk        (clk),
        .rst        (rst),
        .trip       (trip),
        .rise       (rise),
        .mode_latch (mode_latch),
        .shut       (shut),
        .warn_n     (warn_n)
    );

    AST_FAULT_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        fault_off |-> (gate_out == '0)); // R7
endmodule

// File: tb/ocp_limiter_bench.sv
`timescale 1ns/1ps
module ocp_limiter_bench;
    localparam int NSW = 6;
    localparam int TPU = 2;
    localparam int WUS = 20;
    localparam int TO  = TPU * WUS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NSW-1:0] pwm = '0;
    logic [NSW-1:0] oc  = '0;
    logic           md  = 1'b0;
    logic           flt = 1'b0;
    logic [NSW-1:0] gate_out;
    logic           warn_n;

    int    total = 0;
    int    bad   = 0;
    string tag   = "R9";

    always #2.5 clk = ~clk;

    ocp_limiter #(.NSW(NSW), .TICKS_PER_US(TPU), .WINDOW_US(WUS)) u_ocp_limiter (
        .clk        (clk),
        .rst        (rst),
        .pwm_in     (pwm),
        .oc_flag_in (oc),
        .mode_latch (md),
        .fault_off  (flt),
        .gate_out   (gate_out),
        .warn_n     (warn_n)
    );

    // reference model built from the requirements
    logic [NSW-1:0] m_s1, m_s2, m_prev, m_blank, m_pend;
    logic           m_act, m_shut;
    int             m_cnt;

    function automatic logic [NSW-1:0] exp_gate();
        logic [NSW-1:0] g;
        for (int i = 0; i < NSW; i++) begin
            logic fresh;
            fresh = pwm[i] & ~m_prev[i];
            g[i]  = pwm[i] & ~flt & ~m_shut & ~(m_blank[i] & ~fresh);
        end
        return g;
    endfunction

    function automatic logic exp_warn();
        return ~(m_act | m_shut);
    endfunction

    always @(posedge clk) begin
        logic [NSW-1:0] tr, fr, nb, np;
        logic           na;
        int             nc;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_blank <= '0; m_pend <= '0;
            m_act <= 1'b0; m_shut <= 1'b0; m_cnt <= 0;
        end else begin
            tr = '0;
            for (int i = 0; i < NSW; i++) begin
                logic still;
                fr[i] = pwm[i] & ~m_prev[i];
                still = m_blank[i] & ~fr[i];
                if (m_s2[i] && pwm[i] && !flt && !m_shut && !still) tr[i] = 1'b1;
                nb[i] = still | tr[i];
            end
            na = m_act; np = m_pend; nc = m_cnt;
            if (m_act) begin np = m_pend & ~fr; nc = m_cnt + 1; end
            if (tr != '0 && !md) begin
                na = 1'b1; np = np | tr; nc = 0;
            end else if (m_act && (m_cnt == TO - 1 || np == '0)) begin
                na = 1'b0; np = '0; nc = 0;
            end
            m_s1 <= oc; m_s2 <= m_s1; m_prev <= pwm; m_blank <= nb;
            m_act <= na; m_pend <= np; m_cnt <= nc;
            m_shut <= m_shut | (md & (tr != '0));
        end
    end

    task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) begin
            check(tag, "gate_out", 32'(gate_out), 32'(exp_gate()));
            check(tag, "warn_n",   32'(warn_n),   32'(exp_warn()));
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic trip_sw(input int i);
        oc[i] = 1'b1; ticks(3);
        oc[i] = 1'b0; ticks(4);
    endtask

    task automatic cycle_pwm(input int i);
        pwm[i] = 1'b0; tick();
        pwm[i] = 1'b1; ticks(3);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog all-R actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C5A_11E7));
        // R9: reset state
        pwm = 6'h2a; ticks(3);
        check("R9", "gate_out in reset", 32'(gate_out), 32'h2a);
        check("R9", "warn_n in reset", 32'(warn_n), 32'h1);
        rst = 1'b0; ticks(2);
        check("R9", "gate_out after reset", 32'(gate_out), 32'h2a);

        // R1: flags while switches are off, and while fault is active
        tag = "R1"; pwm = '0; oc = '1; ticks(8);
        check("R1", "warn_n with pwm off", 32'(warn_n), 32'h1);
        oc = '0; ticks(3); pwm = '1; ticks(2);
        check("R1", "gate_out after ignored flags", 32'(gate_out), 32'h3f);
        tag = "R7"; flt = 1'b1; oc = '1; ticks(6);
        check("R7", "gate_out under fault", 32'(gate_out), 32'h0);
        check("R1", "warn_n under fault", 32'(warn_n), 32'h1);
        oc = '0; ticks(3); flt = 1'b0; ticks(2);
        check("R1", "gate_out after fault", 32'(gate_out), 32'h3f);

        // R2/R3: single trip, timeout release
        tag = "R2"; trip_sw(0);
        check("R2", "switch 0 blanked", 32'(gate_out), 32'h3e);
        check("R3", "warn_n asserted", 32'(warn_n), 32'h0);
        tag = "R3"; ticks(25);
        check("R3", "warn_n within window", 32'(warn_n), 32'h0);
        ticks(20);
        check("R3", "warn_n after timeout", 32'(warn_n), 32'h1);
        check("R2", "switch 0 still blanked", 32'(gate_out), 32'h3e);
        tag = "R10"; cycle_pwm(0);
        check("R10", "switch 0 back on", 32'(gate_out), 32'h3f);

        // R4: release by new pwm cycle
        tag = "R4"; trip_sw(1);
        check("R4", "warn_n asserted", 32'(warn_n), 32'h0);
        cycle_pwm(1);
        check("R4", "warn_n released by cycle", 32'(warn_n), 32'h1);

        // R5: restart on second switch
        tag = "R5"; trip_sw(2); ticks(23); trip_sw(3); ticks(23);
        check("R5", "warn_n held by restart", 32'(warn_n), 32'h0);
        check("R2", "others keep running", 32'(gate_out), 32'h33);
        ticks(15);
        check("R5", "warn_n released after restart", 32'(warn_n), 32'h1);

        // R6: two pending switches
        tag = "R6"; trip_sw(4); trip_sw(5);
        check("R6", "warn_n two trips", 32'(warn_n), 32'h0);
        cycle_pwm(4);
        check("R6", "warn_n after one cycle", 32'(warn_n), 32'h0);
        cycle_pwm(5);
        check("R6", "warn_n after both cycle", 32'(warn_n), 32'h1);

        // R8: latched shutdown
        tag = "R8"; cycle_pwm(2); cycle_pwm(3);
        md = 1'b1; trip_sw(0);
        check("R8", "gate_out latched", 32'(gate_out), 32'h0);
        check("R8", "warn_n latched", 32'(warn_n), 32'h0);
        md = 1'b0; cycle_pwm(1); ticks(TO + 5);
        check("R8", "gate_out stays off", 32'(gate_out), 32'h0);
        check("R8", "warn_n stays low", 32'(warn_n), 32'h0);
        rst = 1'b1; ticks(2); rst = 1'b0; ticks(2);
        check("R8", "warn_n cleared by reset", 32'(warn_n), 32'h1);
        check("R9", "gate_out after second reset", 32'(gate_out), 32'h3f);

        // constrained random, current-limit mode
        tag = "R2";
        for (int n = 0; n < 4000; n++) begin
            pwm = pwm ^ NSW'($urandom & $urandom & $urandom);
            oc  = NSW'($urandom & $urandom & $urandom & $urandom);
            flt = ($urandom % 64) == 0;
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule